// File: doc/BRIEF.md
# Dead-Time Pair Channel

This block turns one PWM input into a pair of complementary drive signals for a half bridge. A four-state machine delays each edge of the input: the primary signal goes high only after the input has been high for the rising delay, and the complementary signal goes high only after the input has been low for the falling delay. Between these two events both signals are low, which is the dead band. If the input changes level again before a delay has run out, the count starts over for the new level.

Each delay has an active value and a shadow value. The shadow value is copied into the active value on an input edge that software chooses. An output stage comes after the state machine. It applies a per-output dead-time bypass, an optional special-function source on the complementary output, a swap of the two outputs, a per-output forced level and a per-output polarity inversion, in that order. Software sets all of this through a small write-only register port.

State machine: `ST_LOW` (complementary high), `ST_RISE_WAIT` (counting the rising delay, both low), `ST_HIGH` (primary high) and `ST_FALL_WAIT` (counting the falling delay, both low). Transitions: *arm-rise* (LOW→RISE_WAIT, input high and delay non-zero), *fire-rise* (LOW or FALL_WAIT→HIGH when the delay is zero, or RISE_WAIT→HIGH when the count reaches the delay), *arm-fall* (HIGH or RISE_WAIT→FALL_WAIT, input low and delay non-zero), *fire-fall* (→LOW, same rules mirrored), *re-arm* (FALL_WAIT→RISE_WAIT on a pulse shorter than the falling delay).

Top module: `deadband_pair`

## Requirements
- R1: With active rising delay N written at address 4, after the input rises, `out_pri` first reads high after N+1 clock edges (dead time enabled, control address 3 = 0x88).
- R2: With active falling delay N written at address 5, after the input falls, `out_cmp` first reads high after N+1 clock edges.
- R3: The dead-time primary and complementary signals are never high in the same cycle.
- R4: If an input pulse is shorter than the running delay, the count restarts for the new level: the primary stays low, and the complementary goes high after falling delay + 1 edges, counted from the falling edge.
- R5: Setting bit 0 of address 2 reloads the rising delay from its shadow (address 0) on the selected edge. When bit 0 is clear, the shadow value has no effect.
- R6: Setting bit 2 of address 2 reloads the falling delay from its shadow (address 1) on the edge selected by bit 3.
- R7: An edge-select bit (bit 1 for the rising value, bit 3 for the falling value) picks the falling input edge at 0 and the rising input edge at 1. The edge that triggers a reload is already timed with the new value.
- R8: Clearing an output's dead-time enable (address 3, bit 3 for primary, bit 7 for complementary) makes that output follow the input, or its inverse, one edge after the input changes.
- R9: A delay value of 0 lets the edge through with one register stage of latency.
- R10: Address 2 bit 5 = 1 drives the complementary output from a special function chosen by bits 7:6: 0 = input, 1 = inverted input, 2 = delayed primary, 3 = one-cycle pulse on each input edge. Bit 5 = 0 drives it from the inverse dead-time signal.
- R11: Address 3 bit 0 (primary) or bit 4 (complementary) forces that output to the level in bit 1 or bit 5, respectively.
- R12: The output stage works in this order: swap (address 2 bit 4), then forced level, then polarity inversion (address 3 bit 2 for primary, bit 6 for complementary).
- R13: After reset all configuration is zero, `out_pri` is 0 and `out_cmp` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Configuration address |
| cfg_wdata | input | DT_W | Configuration write data |
| pwm_in | input | 1 | PWM input pulse train |
| out_pri | output | 1 | Primary drive output |
| out_cmp | output | 1 | Complementary drive output |

## Verification
The bench builds the block with an 8-bit delay width. This keeps delay values small enough that every pair of rising and falling delays from 0 to 5 can be timed edge by edge. With the input held static, the sweep also covers all 256 output-control codes, with and without swap, at both input levels. Expected values come from arithmetic on the requirement rules. Shadow reload on each edge select, short pulses, dead-time bypass and all four special-function codes are each covered by directed sequences.

// File: rtl/deadband_pkg.sv
package deadband_pkg;

    typedef enum logic [1:0] {
        ST_LOW       = 2'd0,
        ST_RISE_WAIT = 2'd1,
        ST_HIGH      = 2'd2,
        ST_FALL_WAIT = 2'd3
    } db_state_e;

    localparam logic [2:0] A_SH_RISE  = 3'd0;
    localparam logic [2:0] A_SH_FALL  = 3'd1;
    localparam logic [2:0] A_CTRL     = 3'd2;
    localparam logic [2:0] A_OUTCTL   = 3'd3;
    localparam logic [2:0] A_ACT_RISE = 3'd4;
    localparam logic [2:0] A_ACT_FALL = 3'd5;

    // control register bit positions
    localparam int C_RISE_EN   = 0;
    localparam int C_RISE_EDGE = 1;
    localparam int C_FALL_EN   = 2;
    localparam int C_FALL_EDGE = 3;
    localparam int C_SWAP      = 4;
    localparam int C_SRC1      = 5;
    localparam int C_FUNC_LO   = 6;

    // per-output field offsets inside the output-control register
    localparam int O_FORCE = 0;
    localparam int O_LEVEL = 1;
    localparam int O_INV   = 2;
    localparam int O_DTEN  = 3;
    localparam int O_LANE  = 4;

endpackage

// File: rtl/deadband_regs.sv
module deadband_regs
    import deadband_pkg::*;
#(
    parameter int DT_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cfg_we,
    input  logic [2:0]      cfg_addr,
    input  logic [DT_W-1:0] cfg_wdata,
    input  logic            rise_evt,
    input  logic            fall_evt,
    output logic [DT_W-1:0] rise_use,
    output logic [DT_W-1:0] fall_use,
    output logic [7:0]      ctrl,
    output logic [7:0]      outctl
);

    logic [DT_W-1:0] sh_rise, sh_fall, act_rise, act_fall;
    logic            rise_hit, fall_hit;

    // reload trigger: edge select 1 = rising input edge, 0 = falling
    always_comb begin
        rise_hit = ctrl[C_RISE_EN] && (ctrl[C_RISE_EDGE] ? rise_evt : fall_evt);
        fall_hit = ctrl[C_FALL_EN] && (ctrl[C_FALL_EDGE] ? rise_evt : fall_evt);
        rise_use = rise_hit ? sh_rise : act_rise;
        fall_use = fall_hit ? sh_fall : act_fall;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_rise  <= '0;
            sh_fall  <= '0;
            act_rise <= '0;
            act_fall <= '0;
            ctrl     <= '0;
            outctl   <= '0;
        end else begin
            if (cfg_we && cfg_addr == A_SH_RISE) sh_rise <= cfg_wdata;
            if (cfg_we && cfg_addr == A_SH_FALL) sh_fall <= cfg_wdata;
            if (cfg_we && cfg_addr == A_CTRL)    ctrl    <= cfg_wdata[7:0];
            if (cfg_we && cfg_addr == A_OUTCTL)  outctl  <= cfg_wdata[7:0];
            // a direct write wins over a shadow reload in the same cycle
            if (cfg_we && cfg_addr == A_ACT_RISE) act_rise <= cfg_wdata;
            else if (rise_hit)                    act_rise <= sh_rise;
            if (cfg_we && cfg_addr == A_ACT_FALL) act_fall <= cfg_wdata;
            else if (fall_hit)                    act_fall <= sh_fall;
        end
    end

endmodule

// File: rtl/deadband_fsm.sv
module deadband_fsm
    import deadband_pkg::*;
#(
    parameter int DT_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            din,
    input  logic [DT_W-1:0] rise_dt,
    input  logic [DT_W-1:0] fall_dt,
    output logic            dt_hi,
    output logic            dt_lo
);

    db_state_e       st, nxt;
    logic [DT_W-1:0] cnt;

    always_comb begin
        nxt = st;
        unique case (st)
            ST_LOW: begin
                if (din) nxt = (rise_dt == '0) ? ST_HIGH : ST_RISE_WAIT;
            end
            ST_RISE_WAIT: begin
                if (!din)                nxt = (fall_dt == '0) ? ST_LOW : ST_FALL_WAIT;
                else if (cnt >= rise_dt) nxt = ST_HIGH;
            end
            ST_HIGH: begin
                if (!din) nxt = (fall_dt == '0) ? ST_LOW : ST_FALL_WAIT;
            end
            ST_FALL_WAIT: begin
                if (din)                 nxt = (rise_dt == '0) ? ST_HIGH : ST_RISE_WAIT;
                else if (cnt >= fall_dt) nxt = ST_LOW;
            end
        endcase
    end

    // state register and run-length counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st  <= ST_LOW;
            cnt <= '0;
        end else begin
            st <= nxt;
            if (nxt != st)      cnt <= {{(DT_W-1){1'b0}}, 1'b1};
            else if (cnt != '1) cnt <= cnt + 1'b1;
        end
    end

    // outputs decoded from state only
    always_comb begin
        dt_hi = 1'b0;
        dt_lo = 1'b0;
        unique case (st)
            ST_LOW:       dt_lo = 1'b1;
            ST_HIGH:      dt_hi = 1'b1;
            ST_RISE_WAIT,
            ST_FALL_WAIT: ;
        endcase
    end

endmodule

// File: rtl/deadband_outmux.sv
module deadband_outmux
    import deadband_pkg::*;
(
    input  logic       dt_hi,
    input  logic       dt_lo,
    input  logic       in_q,
    input  logic       edge_q,
    input  logic [7:0] ctrl,
    input  logic [7:0] outctl,
    output logic [1:0] outs
);

    logic       f0, f1, special;
    logic [1:0] sw;

    always_comb begin
        unique case (ctrl[C_FUNC_LO +: 2])
            2'd0: special = in_q;
            2'd1: special = ~in_q;
            2'd2: special = dt_hi;
            2'd3: special = edge_q;
        endcase
        f0 = outctl[O_DTEN] ? dt_hi : in_q;
        if (ctrl[C_SRC1]) f1 = special;
        else              f1 = outctl[O_LANE + O_DTEN] ? dt_lo : ~in_q;
        sw[0] = ctrl[C_SWAP] ? f1 : f0;
        sw[1] = ctrl[C_SWAP] ? f0 : f1;
    end

    // per-lane force then invert
    for (genvar g = 0; g < 2; g++) begin : g_lane
        logic lv;
        always_comb begin
            lv      = outctl[g*O_LANE + O_FORCE] ? outctl[g*O_LANE + O_LEVEL] : sw[g];
            outs[g] = lv ^ outctl[g*O_LANE + O_INV];
        end
    end

endmodule

// File: rtl/deadband_pair.sv
module deadband_pair
    import deadband_pkg::*;
#(
    parameter int DT_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cfg_we,
    input  logic [2:0]      cfg_addr,
    input  logic [DT_W-1:0] cfg_wdata,
    input  logic            pwm_in,
    output logic            out_pri,
    output logic            out_cmp
);

    logic            in_q, edge_q;
    logic            rise_evt, fall_evt;
    logic [DT_W-1:0] rise_use, fall_use;
    logic [7:0]      ctrl, outctl;
    logic            dt_hi, dt_lo;
    logic [1:0]      outs;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            in_q   <= 1'b0;
            edge_q <= 1'b0;
        end else begin
            in_q   <= pwm_in;
            edge_q <= pwm_in ^ in_q;
        end
    end

    assign rise_evt = pwm_in & ~in_q;
    assign fall_evt = ~pwm_in & in_q;

    deadband_regs #(.DT_W(DT_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .rise_evt(rise_evt), .fall_evt(fall_evt),
        .rise_use(rise_use), .fall_use(fall_use),
        .ctrl(ctrl), .outctl(outctl)
    );

    deadband_fsm #(.DT_W(DT_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .din(pwm_in),
        .rise_dt(rise_use), .fall_dt(fall_use),
        .dt_hi(dt_hi), .dt_lo(dt_lo)
    );

    deadband_outmux u_mux (
        .dt_hi(dt_hi), .dt_lo(dt_lo), .in_q(in_q), .edge_q(edge_q),
        .ctrl(ctrl), .outctl(outctl), .outs(outs)
    );

    assign out_pri = outs[0];
    assign out_cmp = outs[1];

endmodule

// File: rtl/deadband_chk.sv
module deadband_chk #(
    parameter int DT_W = 16
) (
    input logic            clk,
    input logic            rst_n,
    input logic            pwm_in,
    input logic            dt_hi,
    input logic            dt_lo,
    input logic [DT_W-1:0] rise_use,
    input logic [7:0]      outctl,
    input logic            out_pri
);

    assert_no_overlap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(dt_hi && dt_lo));

    assert_rise_needs_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dt_hi) |-> $past(pwm_in));

    assert_fall_needs_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dt_lo) |-> !$past(pwm_in));

    assert_zero_delay_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (dt_lo && pwm_in && rise_use == '0) |=> dt_hi);

    assert_force_level_R11: assert property (@(posedge clk) disable iff (!rst_n)
        outctl[0] |-> (out_pri == (outctl[1] ^ outctl[2])));

endmodule

bind deadband_pair deadband_chk #(.DT_W(DT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .pwm_in(pwm_in),
    .dt_hi(dt_hi), .dt_lo(dt_lo), .rise_use(rise_use),
    .outctl(outctl), .out_pri(out_pri)
);

// File: tb/deadband_pair_bench.sv
module deadband_pair_bench;

    localparam int CLK_PERIOD = 10;
    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0;
    logic [2:0]    cfg_addr = '0;
    logic [DW-1:0] cfg_wdata = '0;
    logic          pwm_in = 1'b0;
    logic          out_pri, out_cmp;

    int  checks = 0;
    int  failures = 0;
    bit  done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    deadband_pair #(.DT_W(DW)) u_deadband_pair (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .pwm_in(pwm_in),
        .out_pri(out_pri), .out_cmp(out_cmp)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input int d);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = DW'(d);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic settle(input logic lvl);
        pwm_in = lvl;
        repeat (14) @(negedge clk);
    endtask

    // drive a level and return the edge count until the watched output goes high
    task automatic measure(input logic lvl, output int first, output bit both);
        first = 0; both = 0; pwm_in = lvl;
        for (int i = 1; i <= 14; i++) begin
            @(negedge clk);
            if (out_pri && out_cmp) both = 1;
            if (first == 0 && (lvl ? out_pri : out_cmp)) first = i;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int  first;
        bit  both;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R13 reset state
        chk("R13 out_pri", out_pri, 0);
        chk("R13 out_cmp", out_cmp, 1);

        // R1 R2 R3 R9 delay sweep
        wr(3, 8'h88);
        for (int r = 0; r <= 5; r++) begin
            for (int f = 0; f <= 5; f++) begin
                wr(4, r); wr(5, f);
                settle(0);
                measure(1, first, both);
                chk((r == 0) ? "R9 rise zero" : "R1 rise delay", first, r + 1);
                chk("R3 overlap rise", both, 0);
                measure(0, first, both);
                chk((f == 0) ? "R9 fall zero" : "R2 fall delay", first, f + 1);
                chk("R3 overlap fall", both, 0);
            end
        end

        // R4 short pulse
        wr(4, 4); wr(5, 2); wr(2, 0);
        settle(0);
        pwm_in = 1;
        repeat (2) @(negedge clk);
        chk("R4 pri during pulse", out_pri, 0);
        measure(0, first, both);
        chk("R4 cmp restart", first, 3);
        chk("R4 pri never high", both, 0);

        // R5 R7 rising reload on falling edge
        wr(4, 1); wr(5, 0); wr(0, 4); wr(2, 8'h01);
        settle(0);
        measure(1, first, both);
        chk("R5 before reload", first, 2);
        measure(0, first, both);
        measure(1, first, both);
        chk("R5 after falling reload", first, 5);
        // R7 rising-edge reload uses new value on the same edge
        wr(0, 2); wr(2, 8'h03);
        settle(0);
        measure(1, first, both);
        chk("R7 same edge reload", first, 3);
        // R5 disabled reload ignored
        wr(0, 6); wr(2, 8'h00);
        settle(0);
        measure(1, first, both);
        chk("R5 disabled ignored", first, 3);
        // R6 falling reload on rising edge
        wr(1, 3); wr(2, 8'h0C);
        settle(0);
        measure(1, first, both);
        measure(0, first, both);
        chk("R6 fall reload", first, 4);

        // R8 dead time bypass
        wr(2, 0); wr(4, 5); wr(5, 5); wr(3, 8'h80);
        settle(0);
        measure(1, first, both);
        chk("R8 pri bypass", first, 1);
        wr(3, 8'h00);
        measure(0, first, both);
        chk("R8 cmp bypass", first, 1);

        // R10 special function source
        wr(4, 1); wr(5, 1); wr(3, 8'h88);
        for (int lv = 0; lv <= 1; lv++) begin
            settle(lv[0]);
            for (int fn = 0; fn <= 2; fn++) begin
                wr(2, 8'h20 | (fn << 6));
                chk("R10 special", out_cmp, (fn == 1) ? 1 - lv : lv);
            end
        end
        wr(2, 8'hE0);
        settle(0);
        chk("R10 edge idle", out_cmp, 0);
        pwm_in = 1;
        @(negedge clk);
        chk("R10 edge pulse", out_cmp, 1);
        @(negedge clk);
        chk("R10 edge end", out_cmp, 0);

        // R11 R12 output stage sweep
        for (int lv = 0; lv <= 1; lv++) begin
            wr(2, 0);
            settle(lv[0]);
            for (int s = 0; s <= 1; s++) begin
                wr(2, s << 4);
                for (int oc = 0; oc < 256; oc++) begin
                    int f0, f1, s0, s1, e0, e1;
                    wr(3, oc);
                    f0 = lv; f1 = 1 - lv;
                    s0 = s ? f1 : f0;
                    s1 = s ? f0 : f1;
                    e0 = ((oc & 1) ? ((oc >> 1) & 1) : s0) ^ ((oc >> 2) & 1);
                    e1 = ((oc & 16) ? ((oc >> 5) & 1) : s1) ^ ((oc >> 6) & 1);
                    chk((oc & 17) ? "R11 forced pri" : "R12 order pri", out_pri, e0);
                    chk((oc & 17) ? "R11 forced cmp" : "R12 order cmp", out_cmp, e1);
                end
            end
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule